// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3/DDR3L SDRAM interface. It takes the memory from power-on to an idle state in which normal commands are allowed. Once the local reset `rst_n` is released, it holds the memory reset pin low, then releases it, and later raises clock enable. It then loads the four mode registers in the order the memory requires and issues a long ZQ calibration. Last, it waits out the DLL-lock and calibration time and raises `init_done`.

Every wait is a whole number of clock cycles, rounded up from a time given in nanoseconds. The rounding uses the clock-period parameter, so one netlist covers any speed grade. The mode-register contents come from configuration inputs. The block drives them onto the address bus at the cycle each load is issued. The CAS latency inside the MR0 value must suit the clock period: CL 13 at 1.071 ns, 11 at 1.25 ns, 9 at 1.5 ns and 7 at 1.87 ns. The caller is responsible for this.

All memory-side pins come from registers. `ddr_odt` is held low for the whole sequence.

Top module: `ddr3_init_seq`

## Requirements
- R1: After `rst_n` is released, `ddr_reset_n` stays low for exactly ceil(RESET_NS*1000/CLK_PERIOD_PS) clocks and then goes high. While `rst_n` is low, `ddr_reset_n`, `ddr_cke` and `init_done` are 0 and `ddr_cs_n` is 1.
- R2: After `ddr_reset_n` rises, `ddr_cke` stays low for exactly ceil(CKE_NS*1000/CLK_PERIOD_PS) clocks and then goes high.
- R3: `ddr_cke` is never high while `ddr_reset_n` is low.
- R4: After `ddr_cke` rises, NOP appears for exactly max(ceil(TXPR_NS*1000/CLK_PERIOD_PS), 5) clocks before the first mode-register load. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R5: Four mode-register loads follow, each with cs_n=0, ras_n=0, cas_n=0 and we_n=0.
  - The bank address takes the values 2, 3, 1, 0 in that order.
  - Each load drives the matching input `mr2_val`, `mr3_val`, `mr1_val` or `mr0_val` onto `ddr_addr`.
- R6: Successive mode-register loads start exactly TMRD_CK clocks apart. The ZQ calibration starts exactly TMOD_CK clocks after the MR0 load.
- R7: The long ZQ calibration is encoded as cs_n=0, ras_n=1, cas_n=1, we_n=0 and bank 0. It has address bit 10 set and all other address bits clear.
- R8: `init_done` rises exactly max(TZQINIT_CK, TDLLK_CK) clocks after the ZQ calibration cycle. It then stays high until the next reset, with only NOP on the bus.
- R9: The command pins carry deselect (cs_n=1) while `ddr_cke` is low. From the rise of `ddr_cke` onward, every cycle that is not an initialization command carries NOP.
- R10: `ddr_odt` is low in every cycle.
- R11: Asserting `rst_n` at any point returns all outputs at once to their reset values. The next release restarts the whole sequence with the full delays and the current mode-register inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_PERIOD_PS |
| rst_n | input | 1 | Active-low asynchronous reset; release marks supplies stable |
| mr0_val | input | ADDR_W | Contents for mode register 0 |
| mr1_val | input | ADDR_W | Contents for mode register 1 |
| mr2_val | input | ADDR_W | Contents for mode register 2 |
| mr3_val | input | ADDR_W | Contents for mode register 3 |
| ddr_reset_n | output | 1 | Memory reset, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_odt | output | 1 | On-die termination control, held low |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the memory is initialized |

## Verification
Two functions meet in the same cycle.

The first coincidence is inside the shared delay counter. The counter expires and is reloaded on the same edge. In each one-cycle command state it is reloaded with zero, so two expiries fall on consecutive edges. The bench judges this by measuring the exact spacing, in NOP cycles, between every pair of consecutive commands at the pins.

The second coincidence is an asynchronous reset that lands while the sequence is issuing mode-register loads. The bench asserts `rst_n` in the cycle after the second load. It expects every pin back at its reset value before the next edge. It also expects a complete rerun with the full delays and the newly applied mode-register values.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [2:0] {
    ST_RST, ST_CKEW, ST_XPR, ST_MRS, ST_GAP, ST_ZQ, ST_ZQW, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    K_DESEL, K_NOP, K_MRS, K_ZQCL
  } cmd_kind_e;

  // Round a time in ns up to whole clocks of period clk_ps.
  function automatic int ceil_cycles(longint t_ns, longint clk_ps);
    return int'((t_ns * 64'd1000 + clk_ps - 64'd1) / clk_ps);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Bank selected by the k-th mode-register load: 2, 3, 1, 0.
  function automatic logic [2:0] mrs_bank(logic [1:0] k);
    case (k)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int                CNT_W    = 8,
  parameter logic [CNT_W-1:0]  INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= INIT_VAL;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BA_W    = 3,
  parameter int CNT_W   = 8,
  parameter int CKE_CYC = 4,
  parameter int XPR_CYC = 5,
  parameter int TMRD_CK = 4,
  parameter int TMOD_CK = 12,
  parameter int ZQW_CYC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] mr1_val,
  input  logic [ADDR_W-1:0] mr2_val,
  input  logic [ADDR_W-1:0] mr3_val,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output cmd_kind_e         kind,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              rst_lvl,
  output logic              cke_lvl,
  output logic              done_lvl
);

  localparam int ZQ_BIT = 10;
  localparam logic [CNT_W-1:0] D_CKE = CNT_W'(CKE_CYC - 1);
  localparam logic [CNT_W-1:0] D_XPR = CNT_W'(XPR_CYC - 1);
  localparam logic [CNT_W-1:0] D_MRD = CNT_W'(TMRD_CK - 2);
  localparam logic [CNT_W-1:0] D_MOD = CNT_W'(TMOD_CK - 2);
  localparam logic [CNT_W-1:0] D_ZQW = CNT_W'(ZQW_CYC - 2);
  localparam int GAP_W = $clog2(imax(ZQW_CYC, TMOD_CK) + 2);

  seq_state_e state_q, state_d;
  logic [1:0] idx_q;
  logic       idx_inc;
  logic       last_mrs;
  logic [2:0] bank_w;

  // Named events for the checks
  logic mrs_fire, zq_fire, in_done;

  assign last_mrs = (idx_q == 2'd3);
  assign bank_w   = mrs_bank(idx_q);
  assign mrs_fire = (state_q == ST_MRS);
  assign zq_fire  = (state_q == ST_ZQ);
  assign in_done  = (state_q == ST_DONE);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    idx_inc  = 1'b0;
    if (expire) begin
      case (state_q)
        ST_RST:  begin state_d = ST_CKEW; load = 1'b1; load_val = D_CKE; end
        ST_CKEW: begin state_d = ST_XPR;  load = 1'b1; load_val = D_XPR; end
        ST_XPR:  begin state_d = ST_MRS;  load = 1'b1; end
        ST_MRS:  begin
          state_d  = ST_GAP;
          load     = 1'b1;
          load_val = last_mrs ? D_MOD : D_MRD;
        end
        ST_GAP:  begin
          state_d = last_mrs ? ST_ZQ : ST_MRS;
          load    = 1'b1;
          idx_inc = !last_mrs;
        end
        ST_ZQ:   begin state_d = ST_ZQW;  load = 1'b1; load_val = D_ZQW; end
        ST_ZQW:  state_d = ST_DONE;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_inc) idx_q <= idx_q + 2'd1;
    end
  end

  // Command decode
  always_comb begin
    kind = K_NOP;
    ba   = '0;
    addr = '0;
    case (state_q)
      ST_RST, ST_CKEW: kind = K_DESEL;
      ST_MRS: begin
        kind = K_MRS;
        ba   = BA_W'(bank_w);
        case (bank_w)
          3'd0:    addr = mr0_val;
          3'd1:    addr = mr1_val;
          3'd2:    addr = mr2_val;
          default: addr = mr3_val;
        endcase
      end
      ST_ZQ: begin
        kind = K_ZQCL;
        addr = ADDR_W'(1) << ZQ_BIT;
      end
      default: kind = K_NOP;
    endcase
  end

  assign rst_lvl  = (state_q != ST_RST);
  assign cke_lvl  = !(state_q == ST_RST || state_q == ST_CKEW);
  assign done_lvl = in_done;

  // Checker bookkeeping: clocks since the last issued command (saturating)
  logic [GAP_W-1:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gap_cnt <= '1;
    else if (mrs_fire || zq_fire) gap_cnt <= GAP_W'(1);
    else if (gap_cnt != '1)       gap_cnt <= gap_cnt + 1'b1;
  end

  // R6
  mrs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_fire |-> gap_cnt >= GAP_W'(TMRD_CK));

  // R6
  zq_after_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zq_fire |-> gap_cnt >= GAP_W'(TMOD_CK));

  // R8
  done_after_zq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_done) |-> gap_cnt >= GAP_W'(ZQW_CYC));

endmodule

// File: rtl/ddr3_init_pins.sv
module ddr3_init_pins
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind,
  input  logic [BA_W-1:0]   ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rst_lvl,
  input  logic              cke_lvl,
  input  logic              done_lvl,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  logic [3:0] ctl_d;  // {cs_n, ras_n, cas_n, we_n}

  always_comb begin
    case (kind)
      K_MRS:   ctl_d = 4'b0000;
      K_ZQCL:  ctl_d = 4'b0110;
      K_NOP:   ctl_d = 4'b0111;
      default: ctl_d = 4'b1111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_reset_n <= 1'b0;
      ddr_cke     <= 1'b0;
      {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} <= 4'b1111;
      ddr_ba      <= '0;
      ddr_addr    <= '0;
      init_done   <= 1'b0;
    end else begin
      ddr_reset_n <= rst_lvl;
      ddr_cke     <= cke_lvl;
      {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} <= ctl_d;
      ddr_ba      <= ba_in;
      ddr_addr    <= addr_in;
      init_done   <= done_lvl;
    end
  end

  assign ddr_odt = 1'b0;

  logic pin_nop;
  assign pin_nop = !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n;

  // R3
  cke_reset_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_reset_n |-> !ddr_cke);

  // R9
  pre_cke_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cke |-> ddr_cs_n);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> pin_nop);

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 1250,
  parameter int RESET_NS      = 200000,
  parameter int CKE_NS        = 500000,
  parameter int TXPR_NS       = 170,
  parameter int TMRD_CK       = 4,
  parameter int TMOD_CK       = 12,
  parameter int TZQINIT_CK    = 512,
  parameter int TDLLK_CK      = 512,
  parameter int ADDR_W        = 16,
  parameter int BA_W          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] mr1_val,
  input  logic [ADDR_W-1:0] mr2_val,
  input  logic [ADDR_W-1:0] mr3_val,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  localparam int RST_CYC = ceil_cycles(RESET_NS, CLK_PERIOD_PS);
  localparam int CKE_CYC = ceil_cycles(CKE_NS, CLK_PERIOD_PS);
  localparam int XPR_CYC = imax(ceil_cycles(TXPR_NS, CLK_PERIOD_PS), 5);
  localparam int ZQW_CYC = imax(TZQINIT_CK, TDLLK_CK);
  localparam int MAX_CYC = imax(imax(RST_CYC, CKE_CYC),
                                imax(imax(XPR_CYC, ZQW_CYC), TMOD_CK));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             expire, load;
  logic [CNT_W-1:0] load_val;
  cmd_kind_e        kind;
  logic [BA_W-1:0]  ba;
  logic [ADDR_W-1:0] addr;
  logic             rst_lvl, cke_lvl, done_lvl;

  ddr3_init_timer #(
    .CNT_W   (CNT_W),
    .INIT_VAL(CNT_W'(RST_CYC - 1))
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .expire  (expire)
  );

  ddr3_init_fsm #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .CNT_W  (CNT_W),
    .CKE_CYC(CKE_CYC),
    .XPR_CYC(XPR_CYC),
    .TMRD_CK(TMRD_CK),
    .TMOD_CK(TMOD_CK),
    .ZQW_CYC(ZQW_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .mr0_val (mr0_val),
    .mr1_val (mr1_val),
    .mr2_val (mr2_val),
    .mr3_val (mr3_val),
    .load    (load),
    .load_val(load_val),
    .kind    (kind),
    .ba      (ba),
    .addr    (addr),
    .rst_lvl (rst_lvl),
    .cke_lvl (cke_lvl),
    .done_lvl(done_lvl)
  );

  ddr3_init_pins #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .ba_in      (ba),
    .addr_in    (addr),
    .rst_lvl    (rst_lvl),
    .cke_lvl    (cke_lvl),
    .done_lvl   (done_lvl),
    .ddr_reset_n(ddr_reset_n),
    .ddr_cke    (ddr_cke),
    .ddr_odt    (ddr_odt),
    .ddr_cs_n   (ddr_cs_n),
    .ddr_ras_n  (ddr_ras_n),
    .ddr_cas_n  (ddr_cas_n),
    .ddr_we_n   (ddr_we_n),
    .ddr_ba     (ddr_ba),
    .ddr_addr   (ddr_addr),
    .init_done  (init_done)
  );

endmodule

// File: tb/ddr3_init_seq_tb.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb;

  localparam int P_PS   = 5000;
  localparam int RES_NS = 2003;
  localparam int CK_NS  = 5001;
  localparam int XP_NS  = 12;
  localparam int MRD    = 4;
  localparam int MOD    = 12;
  localparam int ZQI    = 256;
  localparam int DLL    = 320;
  localparam int LIM    = 5000;

  // Expected durations worked out here from the requirements
  localparam int EXP_RST = (RES_NS * 1000 + P_PS - 1) / P_PS;   // 401
  localparam int EXP_CKE = (CK_NS * 1000 + P_PS - 1) / P_PS;    // 1001
  localparam int XP_RAW  = (XP_NS * 1000 + P_PS - 1) / P_PS;    // 3
  localparam int EXP_XPR = (XP_RAW < 5) ? 5 : XP_RAW;           // 5
  localparam int EXP_ZQW = (ZQI > DLL) ? ZQI : DLL;             // 320

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] mr0, mr1, mr2, mr3;
  logic ddr_reset_n, ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [2:0]  ddr_ba;
  logic [15:0] ddr_addr;
  logic init_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ddr3_init_seq #(
    .CLK_PERIOD_PS(P_PS), .RESET_NS(RES_NS), .CKE_NS(CK_NS), .TXPR_NS(XP_NS),
    .TMRD_CK(MRD), .TMOD_CK(MOD), .TZQINIT_CK(ZQI), .TDLLK_CK(DLL),
    .ADDR_W(16), .BA_W(3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mr0_val(mr0), .mr1_val(mr1), .mr2_val(mr2), .mr3_val(mr3),
    .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_odt(ddr_odt),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
    .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr),
    .init_done(init_done)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_nop();
    return !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n;
  endfunction

  function automatic logic [15:0] mr_for_bank(logic [2:0] b);
    case (b)
      3'd0:    return mr0;
      3'd1:    return mr1;
      3'd2:    return mr2;
      default: return mr3;
    endcase
  endfunction

  // R1 R11: pins while rst_n is low
  task automatic t_reset_state(string req);
    chk(ddr_reset_n == 1'b0, req, "ddr_reset_n in reset", ddr_reset_n, 0);
    chk(ddr_cke == 1'b0, req, "ddr_cke in reset", ddr_cke, 0);
    chk(ddr_cs_n == 1'b1, req, "ddr_cs_n in reset", ddr_cs_n, 1);
    chk(init_done == 1'b0, req, "init_done in reset", init_done, 0);
    chk(ddr_odt == 1'b0, "R10", "ddr_odt in reset", ddr_odt, 0);
  endtask

  // R1 R2 R3 R9: reset-low and CKE-low windows
  task automatic t_power_phase();
    int n;
    bit cke_bad, desel_bad, odt_bad;
    cke_bad = 0; desel_bad = 0; odt_bad = 0;
    n = 0;
    step();
    while (!ddr_reset_n && n < LIM) begin
      if (ddr_cke) cke_bad = 1;
      if (!ddr_cs_n) desel_bad = 1;
      if (ddr_odt) odt_bad = 1;
      n++;
      step();
    end
    chk(n == EXP_RST, "R1", "reset-low clocks", n, EXP_RST);
    chk(!cke_bad, "R3", "cke high while reset low", cke_bad, 0);
    n = 0;
    while (ddr_reset_n && !ddr_cke && n < LIM) begin
      if (!ddr_cs_n) desel_bad = 1;
      if (ddr_odt) odt_bad = 1;
      n++;
      step();
    end
    chk(n == EXP_CKE, "R2", "cke-low clocks after reset release", n, EXP_CKE);
    chk(ddr_cke == 1'b1, "R2", "cke raised", ddr_cke, 1);
    chk(!desel_bad, "R9", "deselect while cke low", desel_bad, 0);
    chk(!odt_bad, "R10", "odt low in power phase", odt_bad, 0);
  endtask

  // R4: NOP window after cke rise
  task automatic t_xpr();
    int n;
    n = 0;
    while (is_nop() && n < LIM) begin
      n++;
      step();
    end
    chk(n == EXP_XPR, "R4", "NOP clocks before first MRS", n, EXP_XPR);
  endtask

  // R5 R6 R9: nk mode-register loads with spacing
  task automatic t_mrs(int nk);
    logic [2:0] order [4];
    int n;
    int exp_gap;
    order[0] = 3'd2; order[1] = 3'd3; order[2] = 3'd1; order[3] = 3'd0;
    for (int k = 0; k < nk; k++) begin
      chk(!ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n, "R5", "MRS encoding",
          {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 0);
      chk(ddr_ba == order[k], "R5", "MRS bank order", ddr_ba, order[k]);
      chk(ddr_addr == mr_for_bank(order[k]), "R5", "MRS address value",
          ddr_addr, mr_for_bank(order[k]));
      if (k == nk - 1 && nk < 4) return;
      step();
      n = 0;
      while (is_nop() && n < LIM) begin
        n++;
        step();
      end
      exp_gap = (k < 3) ? MRD - 1 : MOD - 1;
      chk(n == exp_gap, "R6", "NOP clocks after MRS", n, exp_gap);
    end
  endtask

  // R7 R8 R9 R10: ZQ calibration and completion
  task automatic t_zq_done();
    int n;
    bit nop_bad;
    chk(!ddr_cs_n && ddr_ras_n && ddr_cas_n && !ddr_we_n, "R7", "ZQCL encoding",
        {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 4'b0110);
    chk(ddr_addr == 16'h0400, "R7", "ZQCL address", ddr_addr, 16'h0400);
    chk(ddr_ba == 3'd0, "R7", "ZQCL bank", ddr_ba, 0);
    nop_bad = 0;
    n = 0;
    step();
    while (!init_done && n < LIM) begin
      if (!is_nop()) nop_bad = 1;
      n++;
      step();
    end
    chk(n == EXP_ZQW - 1, "R8", "clocks from ZQCL to done minus one", n, EXP_ZQW - 1);
    chk(!nop_bad, "R9", "NOP during ZQ wait", nop_bad, 0);
    nop_bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (!init_done || !is_nop() || ddr_odt) nop_bad = 1;
      step();
    end
    chk(!nop_bad, "R8", "done held with NOP idle", nop_bad, 0);
  endtask

  task automatic t_full_run();
    t_power_phase();
    t_xpr();
    t_mrs(4);
    t_zq_done();
  endtask

  // R11: reset in the middle of the mode-register loads
  task automatic t_mid_reset();
    t_power_phase();
    t_xpr();
    t_mrs(2);
    step();
    rst_n = 1'b0;
    #1;
    t_reset_state("R11");
    repeat (3) step();
  endtask

  initial begin
    #(20000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mr0 = 16'h1D70; mr1 = 16'h0044; mr2 = 16'h0218; mr3 = 16'h0003;
    repeat (3) step();
    t_reset_state("R1");
    rst_n = 1'b1;
    t_full_run();

    rst_n = 1'b0;
    repeat (2) step();
    mr0 = 16'hA5C3; mr1 = 16'h5A3C; mr2 = 16'h0F0F; mr3 = 16'hF0F0;
    rst_n = 1'b1;
    t_mid_reset();

    mr0 = 16'h0920; mr1 = 16'h0006; mr2 = 16'h0008; mr3 = 16'h0004;
    rst_n = 1'b1;
    t_full_run();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule